// File: doc/BRIEF.md
# Manchester Timing Frame Receiver and Classifier

This block receives timing frames from a Manchester-coded serial line and recovers them with an oversampling system clock. Each bit cell is split into two halves. The two half levels are always opposite, and the direction of the change in the middle of the cell gives the bit value. The receiver locks onto every mid-cell change, so a slow drift in the sender's rate does not build up over the frame. After the frame has been checked, the block sorts it by its type field and sends it to one of several handlers.

A millisecond frame produces a single-cycle tick. An event frame produces a single-cycle strobe that carries the code and payload. Counter and interrupt logic further down the chip use this strobe. Two time-of-day frames are joined into one 32-bit seconds value. Telegram frames fill a hidden bank of slots. An end marker makes that bank visible to readers, so a reader always sees a complete telegram. The block drops frames that fail a check and reports why: a broken cell is flagged as a code violation, and bad parity or a bad stop bit is counted as a frame error.

Top module: `tfr_frame_rx`

## Requirements
- R1: The line idles low. A bit cell lasts SPB clock cycles. A 1 is sent as high then low, and a 0 as low then high. A frame is a start bit (1), then 32 data bits MSB first, then an even parity bit equal to the XOR of the data bits, then a stop bit (0). Frames are decoded correctly when every half-cell is stretched or shortened by up to SPB/8 cycles, because the bit timing realigns on each mid-cell transition.
- R2: The data word splits as accelerator [31:28], type [27:24], code [23:16] and payload [15:0]. A valid frame of type 4 raises ev_stb for exactly one cycle, with ev_accel, ev_code and ev_payload taken from the frame. Those outputs hold their values between strobes.
- R3: A valid frame of type 1 raises ms_tick for exactly one cycle and has no other effect.
- R4: A frame of type 2 with code 0x00 carries the upper 16 bits of the seconds value. A frame of type 2 with code 0x01 carries the lower 16 bits. When a low half follows a high half, utc_sec takes {high, low} in a single update, and utc_upd pulses in the same cycle. utc_sec changes at no other time.
- R5: A low half that has no pending high half is discarded. A high half that arrives while another is pending replaces the pending one. Each high half is used at most once.
- R6: A frame of type 3 whose code[7:5] is 0 writes its payload to slot code[4:0] of the hidden bank. Code 0x00 also writes slot 0 and then swaps the banks, and tg_swap pulses. tg_rd_data shows the visible bank at tg_rd_addr and changes only on a swap or on a change of address.
- R7: A frame of type 3 whose code[7:5] is not zero writes nothing and causes no swap.
- R8: A frame that has a parity error or a stop bit of 1 is dropped. frame_err pulses, and err_count increases by one and holds at its maximum value.
- R9: If a bit cell has no transition within a quarter cell of its middle, cv_err pulses and the partial frame is discarded. err_count is not changed.
- R10: Frames of types 0 and 5 to 15 produce no output.
- R11: After reset, all strobes and flags are low, utc_sec and err_count are 0, and both telegram banks read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 1 | Manchester line, asynchronous |
| tg_rd_addr | input | $clog2(TG_SLOTS) | Telegram read slot |
| ms_tick | output | 1 | Millisecond tick |
| ev_stb | output | 1 | Event strobe |
| ev_accel | output | 4 | Accelerator field of the last event |
| ev_code | output | 8 | Code of the last event |
| ev_payload | output | 16 | Payload of the last event |
| utc_sec | output | 32 | Time-of-day seconds |
| utc_upd | output | 1 | Pulses when utc_sec is updated |
| tg_rd_data | output | 16 | Visible telegram slot contents |
| tg_swap | output | 1 | Pulses when the telegram banks swap |
| cv_err | output | 1 | Code violation flag |
| frame_err | output | 1 | Parity or stop error flag |
| err_count | output | ERR_W | Frame error count |

## Verification
If the bit timing loses its alignment, the fault shows up within a single frame time. The frame ends with a cv_err pulse, or with a frame_err pulse and a higher err_count, instead of the expected strobe, which is why the bench also sends frames with stretched and shortened cells. A wrong UTC pending state or a wrong telegram bank select does not show up when the frame arrives. It appears only on the next low half, or on the next read after a marker, so the bench reads slots and seconds values after every such sequence. A misclassified type shows up as a strobe on the wrong output about four cycles after the stop bit.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

   typedef struct packed {
      logic [3:0]  accel;
      logic [3:0]  ftype;
      logic [7:0]  code;
      logic [15:0] payload;
   } frame_t;

   localparam int FRAME_W = $bits(frame_t);

   localparam logic [3:0] FT_MSEC  = 4'h1;
   localparam logic [3:0] FT_UTC   = 4'h2;
   localparam logic [3:0] FT_TELEG = 4'h3;
   localparam logic [3:0] FT_EVENT = 4'h4;

   localparam logic [7:0] UTC_HI_CODE = 8'h00;
   localparam logic [7:0] UTC_LO_CODE = 8'h01;
   localparam logic [7:0] TG_END_CODE = 8'h00;

endpackage

// File: rtl/tfr_line_sync.sv
module tfr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tfr_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-1:0], line_i};
   end

   assign lvl_o  = sr[STAGES-1];
   assign edge_o = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/tfr_manchester_rx.sv
module tfr_manchester_rx #(
   parameter int SPB   = 80,
   parameter int NBITS = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic             edge_i,
   output logic             done_o,
   output logic             cv_o,
   output logic [NBITS-1:0] bits_o
);
   localparam int CW     = $clog2(SPB);
   localparam int IW     = $clog2(NBITS);
   localparam int HALF   = SPB / 2;
   localparam int QTR    = SPB / 4;
   localparam int THREEQ = (3 * SPB) / 4;
   localparam logic [CW-1:0] C_ONE   = CW'(1);
   localparam logic [CW-1:0] C_HALF1 = CW'(HALF + 1);
   localparam logic [CW-1:0] C_QTR   = CW'(QTR);
   localparam logic [CW-1:0] C_3Q    = CW'(THREEQ);
   localparam logic [CW-1:0] C_LAST  = CW'(SPB - 1);
   localparam logic [IW-1:0] I_LAST  = IW'(NBITS - 1);

   generate
      if (SPB < 8 || (SPB % 4) != 0) begin : g_bad_spb
         $error("tfr_manchester_rx: SPB must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic          busy;
   logic          mid_seen;
   logic [CW-1:0] cnt;
   logic [IW-1:0] bidx;
   logic          in_win;
   logic          take;

   // mid-cell window spans a quarter cell on either side of the centre
   assign in_win = (cnt >= C_QTR) && (cnt <= C_3Q);
   assign take   = busy && edge_i && in_win && !mid_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mid_seen <= 1'b0;
         cnt      <= '0;
         bidx     <= '0;
         bits_o   <= '0;
         done_o   <= 1'b0;
         cv_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         cv_o   <= 1'b0;
         if (!busy) begin
            if (edge_i && lvl_i) begin
               busy     <= 1'b1;
               cnt      <= C_ONE;
               mid_seen <= 1'b0;
               bidx     <= '0;
            end
         end else if (take) begin
            // level after a falling centre transition is low: bit is 1
            bits_o   <= {bits_o[NBITS-2:0], ~lvl_i};
            mid_seen <= 1'b1;
            cnt      <= C_HALF1;
            if (bidx == I_LAST) begin
               busy   <= 1'b0;
               done_o <= 1'b1;
            end else begin
               bidx <= bidx + 1'b1;
            end
         end else if (!mid_seen && cnt == C_3Q) begin
            cv_o <= 1'b1;
            busy <= 1'b0;
         end else begin
            if (cnt == C_LAST) begin
               cnt      <= '0;
               mid_seen <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tfr_utc_join.sv
module tfr_utc_join #(
   parameter int HW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hi_stb,
   input  logic          lo_stb,
   input  logic [HW-1:0] half_i,
   output logic [2*HW-1:0] sec_o,
   output logic          upd_o
);
   logic          pending;
   logic [HW-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         hold    <= '0;
         sec_o   <= '0;
         upd_o   <= 1'b0;
      end else begin
         upd_o <= 1'b0;
         if (hi_stb) begin
            hold    <= half_i;
            pending <= 1'b1;
         end else if (lo_stb && pending) begin
            sec_o   <= {hold, half_i};
            upd_o   <= 1'b1;
            pending <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tfr_teleg_dbuf.sv
module tfr_teleg_dbuf #(
   parameter int SLOTS = 32,
   parameter int WW    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic [$clog2(SLOTS)-1:0] wr_slot,
   input  logic [WW-1:0]            wr_data,
   input  logic                     swap_stb,
   input  logic [$clog2(SLOTS)-1:0] rd_addr,
   output logic [WW-1:0]            rd_data,
   output logic                     swap_o
);
   generate
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("tfr_teleg_dbuf: SLOTS must be a power of two");
      end
   endgenerate

   logic [WW-1:0] mem [2][SLOTS];
   logic          vis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis    <= 1'b0;
         swap_o <= 1'b0;
         for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < SLOTS; s++) mem[b][s] <= '0;
         end
      end else begin
         swap_o <= 1'b0;
         if (wr_stb) mem[!vis][wr_slot] <= wr_data;
         if (swap_stb) begin
            vis    <= ~vis;
            swap_o <= 1'b1;
         end
      end
   end

   assign rd_data = mem[vis][rd_addr];
endmodule

// File: rtl/tfr_frame_rx.sv
module tfr_frame_rx #(
   parameter int SPB          = 80,
   parameter int SYNC_STAGES  = 2,
   parameter int TG_SLOTS     = 32,
   parameter int ERR_W        = 8,
   parameter bit ERR_SATURATE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_i,
   input  logic [$clog2(TG_SLOTS)-1:0] tg_rd_addr,
   output logic                        ms_tick,
   output logic                        ev_stb,
   output logic [3:0]                  ev_accel,
   output logic [7:0]                  ev_code,
   output logic [15:0]                 ev_payload,
   output logic [31:0]                 utc_sec,
   output logic                        utc_upd,
   output logic [15:0]                 tg_rd_data,
   output logic                        tg_swap,
   output logic                        cv_err,
   output logic                        frame_err,
   output logic [ERR_W-1:0]            err_count
);
   import tfr_pkg::*;

   localparam int NBITS = FRAME_W + 3;
   localparam int SW    = $clog2(TG_SLOTS);

   generate
      if (TG_SLOTS > 128) begin : g_bad_tg
         $error("tfr_frame_rx: TG_SLOTS must not exceed the code range");
      end
      if (ERR_W < 1) begin : g_bad_err
         $error("tfr_frame_rx: ERR_W must be positive");
      end
   endgenerate

   logic             s_lvl, s_edge;
   logic             rx_done, rx_cv;
   logic [NBITS-1:0] rx_bits;
   frame_t           fr;
   logic             par_ok, good, bad;
   logic             utc_hi, utc_lo, tg_wr, tg_end;

   tfr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(line_i),
      .lvl_o(s_lvl), .edge_o(s_edge)
   );

   tfr_manchester_rx #(.SPB(SPB), .NBITS(NBITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .lvl_i(s_lvl), .edge_i(s_edge),
      .done_o(rx_done), .cv_o(rx_cv), .bits_o(rx_bits)
   );

   // frame layout in the shift register: start, data, parity, stop
   assign fr     = rx_bits[NBITS-2:2];
   assign par_ok = ((^fr) == rx_bits[1]);
   assign good   = rx_done && rx_bits[NBITS-1] && par_ok && !rx_bits[0];
   assign bad    = rx_done && !good;

   assign utc_hi = good && fr.ftype == FT_UTC && fr.code == UTC_HI_CODE;
   assign utc_lo = good && fr.ftype == FT_UTC && fr.code == UTC_LO_CODE;
   assign tg_wr  = good && fr.ftype == FT_TELEG && fr.code[7:SW] == '0;
   assign tg_end = tg_wr && fr.code == TG_END_CODE;

   tfr_utc_join #(.HW(16)) u_utc (
      .clk(clk), .rst_n(rst_n), .hi_stb(utc_hi), .lo_stb(utc_lo),
      .half_i(fr.payload), .sec_o(utc_sec), .upd_o(utc_upd)
   );

   tfr_teleg_dbuf #(.SLOTS(TG_SLOTS), .WW(16)) u_tg (
      .clk(clk), .rst_n(rst_n), .wr_stb(tg_wr), .wr_slot(fr.code[SW-1:0]),
      .wr_data(fr.payload), .swap_stb(tg_end), .rd_addr(tg_rd_addr),
      .rd_data(tg_rd_data), .swap_o(tg_swap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_tick    <= 1'b0;
         ev_stb     <= 1'b0;
         ev_accel   <= '0;
         ev_code    <= '0;
         ev_payload <= '0;
         cv_err     <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         ms_tick   <= good && fr.ftype == FT_MSEC;
         ev_stb    <= good && fr.ftype == FT_EVENT;
         cv_err    <= rx_cv;
         frame_err <= bad;
         if (good && fr.ftype == FT_EVENT) begin
            ev_accel   <= fr.accel;
            ev_code    <= fr.code;
            ev_payload <= fr.payload;
         end
      end
   end

   generate
      if (ERR_SATURATE) begin : g_err_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       err_count <= '0;
            else if (bad && err_count != '1)  err_count <= err_count + 1'b1;
         end
      end else begin : g_err_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    err_count <= '0;
            else if (bad)  err_count <= err_count + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/tfr_frame_rx_chk.sv
module tfr_frame_rx_chk #(
   parameter int TG_SLOTS = 32,
   parameter int ERR_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ms_tick,
   input logic                        ev_stb,
   input logic [3:0]                  ev_accel,
   input logic [7:0]                  ev_code,
   input logic [15:0]                 ev_payload,
   input logic [31:0]                 utc_sec,
   input logic                        utc_upd,
   input logic [$clog2(TG_SLOTS)-1:0] tg_rd_addr,
   input logic [15:0]                 tg_rd_data,
   input logic                        tg_swap,
   input logic                        cv_err,
   input logic                        frame_err,
   input logic [ERR_W-1:0]            err_count
);
   p_ev_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stb |=> !ev_stb);

   p_ev_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_stb |-> ($stable(ev_code) && $stable(ev_payload) && $stable(ev_accel)));

   p_ms_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |=> !ms_tick);

   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ms_tick, ev_stb, utc_upd, tg_swap, cv_err, frame_err}));

   p_utc_atomic_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !utc_upd |-> $stable(utc_sec));

   p_tg_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tg_swap && $stable(tg_rd_addr)) |-> $stable(tg_rd_data));

   p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && $past(err_count) != '1) |-> err_count == $past(err_count) + 1'b1);

   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_err |-> $stable(err_count));
endmodule

bind tfr_frame_rx tfr_frame_rx_chk #(.TG_SLOTS(TG_SLOTS), .ERR_W(ERR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ev_stb(ev_stb),
   .ev_accel(ev_accel), .ev_code(ev_code), .ev_payload(ev_payload),
   .utc_sec(utc_sec), .utc_upd(utc_upd), .tg_rd_addr(tg_rd_addr),
   .tg_rd_data(tg_rd_data), .tg_swap(tg_swap), .cv_err(cv_err),
   .frame_err(frame_err), .err_count(err_count)
);

// File: tb/tfr_frame_rx_test.sv
module tfr_frame_rx_test;
   localparam int SPB   = 16;
   localparam int HB    = SPB / 2;
   localparam int ERR_W = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_i = 1'b0;
   logic [4:0]  tg_rd_addr = '0;
   logic        ms_tick, ev_stb, utc_upd, tg_swap, cv_err, frame_err;
   logic [3:0]  ev_accel;
   logic [7:0]  ev_code;
   logic [15:0] ev_payload, tg_rd_data;
   logic [31:0] utc_sec;
   logic [ERR_W-1:0] err_count;

   int checks = 0, fails = 0;
   int n_ev = 0, n_ms = 0, n_utc = 0, n_sw = 0, n_cv = 0, n_fe = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tfr_frame_rx #(.SPB(SPB), .TG_SLOTS(32), .ERR_W(ERR_W)) uut (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .tg_rd_addr(tg_rd_addr),
      .ms_tick(ms_tick), .ev_stb(ev_stb), .ev_accel(ev_accel), .ev_code(ev_code),
      .ev_payload(ev_payload), .utc_sec(utc_sec), .utc_upd(utc_upd),
      .tg_rd_data(tg_rd_data), .tg_swap(tg_swap), .cv_err(cv_err),
      .frame_err(frame_err), .err_count(err_count)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_stb)    n_ev++;
         if (ms_tick)   n_ms++;
         if (utc_upd)   n_utc++;
         if (tg_swap)   n_sw++;
         if (cv_err)    n_cv++;
         if (frame_err) n_fe++;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] t,
                                      input logic [7:0] c, input logic [15:0] p);
      return {a, t, c, p};
   endfunction

   task automatic half_cell(input logic lv, input int len);
      line_i = lv;
      repeat (len) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int hl);
      if (b) begin half_cell(1'b1, hl); half_cell(1'b0, hl); end
      else   begin half_cell(1'b0, hl); half_cell(1'b1, hl); end
   endtask

   task automatic send_raw(input logic [31:0] w, input logic par, input logic stp, input int hl);
      send_bit(1'b1, hl);
      for (int i = 31; i >= 0; i--) send_bit(w[i], hl);
      send_bit(par, hl);
      send_bit(stp, hl);
      line_i = 1'b0;
      repeat (3 * SPB) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] w);
      send_raw(w, ^w, 1'b0, HB);
   endtask

   task automatic read_tg(input logic [4:0] a, output logic [15:0] d);
      tg_rd_addr = a;
      @(negedge clk);
      d = tg_rd_data;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      check("R11 ev_stb", ev_stb, 0);
      check("R11 ms_tick", ms_tick, 0);
      check("R11 utc_sec", utc_sec, 0);
      check("R11 err_count", err_count, 0);
      check("R11 flags", {cv_err, frame_err, tg_swap, utc_upd}, 0);
      read_tg(5'd7, d);
      check("R11 telegram slot", d, 0);
   endtask

   task automatic t_event;
      int e0 = n_ev;
      send(mk(4'hA, 4'h4, 8'h5C, 16'hBEEF));
      check("R2 event count", n_ev - e0, 1);
      check("R2 event fields", {ev_accel, ev_code, ev_payload}, {4'hA, 8'h5C, 16'hBEEF});
      send(mk(4'h0, 4'h4, 8'hFF, 16'h0001));
      check("R2 second event", {n_ev - e0, ev_code, ev_payload}, {32'd2, 8'hFF, 16'h0001});
   endtask

   task automatic t_msec;
      int e0 = n_ev, m0 = n_ms;
      send(mk(4'h3, 4'h1, 8'h00, 16'h0000));
      check("R3 tick count", n_ms - m0, 1);
      check("R3 no event", n_ev - e0, 0);
   endtask

   task automatic t_utc;
      int u0 = n_utc;
      send(mk(4'h0, 4'h2, 8'h00, 16'h1234));
      check("R4 high half alone", {n_utc - u0, utc_sec}, {32'd0, 32'h0});
      send(mk(4'h0, 4'h2, 8'h01, 16'h5678));
      check("R4 joined seconds", {n_utc - u0, utc_sec}, {32'd1, 32'h12345678});
      send(mk(4'h0, 4'h2, 8'h01, 16'hAAAA));
      check("R5 lone low ignored", {n_utc - u0, utc_sec}, {32'd1, 32'h12345678});
      send(mk(4'h0, 4'h2, 8'h00, 16'h1111));
      send(mk(4'h0, 4'h2, 8'h00, 16'h2222));
      send(mk(4'h0, 4'h2, 8'h01, 16'h3333));
      check("R5 high replaced", {n_utc - u0, utc_sec}, {32'd2, 32'h22223333});
   endtask

   task automatic t_teleg;
      logic [15:0] d;
      int s0 = n_sw;
      send(mk(4'h0, 4'h3, 8'h03, 16'hC0DE));
      send(mk(4'h0, 4'h3, 8'h1F, 16'hF00D));
      read_tg(5'd3, d);
      check("R6 hidden before marker", d, 16'h0);
      send(mk(4'h0, 4'h3, 8'h00, 16'h7777));
      check("R6 swap count", n_sw - s0, 1);
      read_tg(5'd3, d);  check("R6 slot 3", d, 16'hC0DE);
      read_tg(5'd31, d); check("R6 slot 31", d, 16'hF00D);
      read_tg(5'd0, d);  check("R6 marker slot 0", d, 16'h7777);
      send(mk(4'h0, 4'h3, 8'h03, 16'h1234));
      read_tg(5'd3, d);  check("R6 refill isolated", d, 16'hC0DE);
      send(mk(4'h0, 4'h3, 8'h23, 16'h9999));
      check("R7 no swap on high code", n_sw - s0, 1);
      send(mk(4'h0, 4'h3, 8'h00, 16'h0000));
      read_tg(5'd3, d);  check("R7 slot not overwritten", d, 16'h1234);
      read_tg(5'd31, d); check("R6 second bank slot 31", d, 16'h0);
   endtask

   task automatic t_errors;
      int e0 = n_ev, f0 = n_fe;
      logic [31:0] w = mk(4'h1, 4'h4, 8'h11, 16'h2222);
      send_raw(w, ~(^w), 1'b0, HB);
      check("R8 bad parity", {n_ev - e0, n_fe - f0, 29'd0, err_count}, {32'd0, 32'd1, 32'd1});
      send_raw(w, ^w, 1'b1, HB);
      check("R8 bad stop", {n_ev - e0, n_fe - f0, 29'd0, err_count}, {32'd0, 32'd2, 32'd2});
      for (int k = 0; k < 6; k++) send_raw(w, ~(^w), 1'b0, HB);
      check("R8 saturated count", err_count, 7);
   endtask

   task automatic t_violation;
      int c0 = n_cv, e0 = n_ev;
      send_bit(1'b1, HB);
      send_bit(1'b0, HB);
      send_bit(1'b1, HB);
      line_i = 1'b0;
      repeat (3 * SPB) @(negedge clk);
      check("R9 violation flagged", n_cv - c0, 1);
      check("R9 no count, no event", {n_ev - e0, 29'd0, err_count}, {32'd0, 32'd7});
      send(mk(4'h2, 4'h4, 8'h42, 16'h4242));
      check("R9 recovery", {n_ev - e0, ev_payload}, {32'd1, 16'h4242});
   endtask

   task automatic t_drift;
      int e0 = n_ev;
      logic [31:0] w = mk(4'h5, 4'h4, 8'hA5, 16'h5AC3);
      send_raw(w, ^w, 1'b0, HB + 1);
      check("R1 slow line", {n_ev - e0, ev_code, ev_payload}, {32'd1, 8'hA5, 16'h5AC3});
      w = mk(4'h6, 4'h4, 8'h3C, 16'hF0F0);
      send_raw(w, ^w, 1'b0, HB - 1);
      check("R1 fast line", {n_ev - e0, ev_code, ev_payload}, {32'd2, 8'h3C, 16'hF0F0});
   endtask

   task automatic t_unknown;
      int tot = n_ev + n_ms + n_utc + n_sw + n_cv + n_fe;
      logic [15:0] d;
      send(mk(4'h0, 4'h0, 8'h01, 16'hDEAD));
      send(mk(4'h0, 4'hF, 8'h00, 16'hBEEF));
      send(mk(4'h0, 4'h5, 8'h03, 16'hCAFE));
      check("R10 no strobes", (n_ev + n_ms + n_utc + n_sw + n_cv + n_fe) - tot, 0);
      check("R10 utc untouched", utc_sec, 32'h22223333);
      read_tg(5'd3, d);
      check("R10 telegram untouched", d, 16'h1234);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_event();
      t_msec();
      t_utc();
      t_teleg();
      t_errors();
      t_violation();
      t_drift();
      t_unknown();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule